// File: doc/BRIEF.md
# Multi-Lane Pixel Deserializer with Parity Screening

This block collects a 30-bit pixel frame from one, two or three serial lanes and presents it as a 27-bit parallel word: 24 colour bits and three sync/control bits (vertical sync, horizontal sync, data enable). The block runs on a single system clock. A bit-clock edge is signalled by the one-cycle input `bitStrobe`, and all active lanes are sampled on that cycle. Each frame carries an even-parity bit and two fixed framing bits. A frame that fails parity is dropped and the previous word stays on the bus. A frame whose framing bits are wrong is not emitted, and the frame window then slides forward by one lane group for each following bit strobe until it locks.

A two-bit link select sets the lane count at run time. A swap input mirrors the colour bit order on the output bus. When the bit clock stops, or when receive enable is low, the bus is driven to a fixed idle pattern: every bit is high except data enable, and the pixel strobe stays low. Clock loss is detected by counting system cycles without a bit strobe.

Top module: `pix_deser`

## Requirements
- R1: `linkSel` sets the lane count: 00 gives 1 lane (30 bit strobes per frame), 01 gives 2 lanes (15 strobes) and 10 gives 3 lanes (10 strobes). On each strobe, lane i carries frame bit `step*laneCount + i`.
- R2: Frame bit k, for k from 0 to 26, is word bit k. The word fields are [26:19] red, [18:11] green, [10:3] blue, [2] VS, [1] HS and [0] DE. On the clock edge that samples the last bit of a good frame, `pixelOut` takes the new word and `pixelStrobe` goes high for exactly that one cycle.
- R3: Frame bit 27 makes the XOR of frame bits 0 to 27 equal 0. If the check fails, `pixelStrobe` and `parityErr` pulse together for one cycle and `pixelOut` keeps its previous word.
- R4: Frame bit 28 must be 1 and frame bit 29 must be 0. A completed window with other values produces no strobe and no error, and the window is re-evaluated, shifted by one lane group, on each following bit strobe.
- R5: With `swapOrder` high, `pixelOut[26:19]` holds blue with its bit 0 at bit 26, `[18:11]` holds green reversed in the same way, `[10:3]` holds red reversed, and `[2:0]` is unchanged. The output follows `swapOrder` in the same cycle.
- R6: After IDLE_LIMIT consecutive cycles without a bit strobe, `pixelOut` becomes 27'h7FFFFFE (all bits high except DE), the strobes stay low and any partial frame is discarded.
- R7: While `rxEnable` is low, the next edge drives the idle pattern, bit strobes are ignored, and the first frame after re-enable starts from frame bit 0.
- R8: While reset is applied and after it is released, `pixelOut` shows the idle pattern and both strobes are low until a frame completes.
- R9: `linkSel` 11 behaves exactly like 10 (3 lanes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxEnable | input | 1 | Receive enable; low puts the block into shutdown |
| linkSel | input | 2 | Lane-count select |
| bitStrobe | input | 1 | One-cycle mark of a bit-clock edge |
| serialIn | input | 3 | Serial lane data, lane 0 in bit 0 |
| swapOrder | input | 1 | Mirror colour bit order on the output |
| pixelOut | output | 27 | Parallel pixel word |
| pixelStrobe | output | 1 | One-cycle pulse per completed frame |
| parityErr | output | 1 | One-cycle pulse for a dropped bad-parity frame |

## Verification
A wrong step count or lane mapping shows as a strobe on the wrong bit strobe, or as a scrambled word, within one frame time. Broken parity or framing logic shows as a changed word during an error pulse, or as a strobe where none belongs, on the edge that ends the frame. A watchdog counter that is off by one moves the idle pattern by one cycle. The bench compares all outputs against its own model on every cycle, so any of these faults is reported in the cycle where it first appears.

// File: rtl/pix_deser_pkg.sv
package pix_deser_pkg;
  localparam int FRAME_W   = 30;
  localparam int DATA_W    = 27;
  localparam int COLOR_W   = 8;
  localparam int MAX_LANES = 3;
  localparam int PAR_POS   = DATA_W;
  localparam int SYNC0_POS = DATA_W + 1;
  localparam int SYNC1_POS = DATA_W + 2;
  localparam int STEP_W    = $clog2(FRAME_W + 1);
  localparam int BLUE_LO   = 3;
  localparam int GREEN_LO  = BLUE_LO + COLOR_W;
  localparam int RED_LO    = GREEN_LO + COLOR_W;
  localparam logic [DATA_W-1:0] IDLE_WORD = {{(DATA_W-1){1'b1}}, 1'b0};

  typedef struct packed {
    logic       shiftEn;
    logic       loadWord;
    logic       goIdle;
    logic [1:0] laneCnt;
  } ctrl_t;
endpackage

// File: rtl/pix_deser_ctrl.sv
module pix_deser_ctrl
  import pix_deser_pkg::*;
#(
  parameter int IDLE_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic [1:0] linkSel,
  input  logic       bitStrobe,
  input  logic       framingOk,
  input  logic       parityOk,
  output ctrl_t      ctrl,
  output logic       pixelStrobe,
  output logic       parityErr
);
  localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_LIMIT);

  logic [CNT_W-1:0]  missCnt, missNext;
  logic [STEP_W-1:0] stepCnt, stepsNeeded;
  logic [1:0]        laneCnt;
  logic              lastStep, complete;

  always_comb begin
    unique case (linkSel)
      2'b00:   begin laneCnt = 2'd1; stepsNeeded = STEP_W'(FRAME_W);     end
      2'b01:   begin laneCnt = 2'd2; stepsNeeded = STEP_W'(FRAME_W / 2); end
      default: begin laneCnt = 2'd3; stepsNeeded = STEP_W'(FRAME_W / 3); end
    endcase
  end

  always_comb begin
    if (!rxEnable)          missNext = LIMIT;
    else if (bitStrobe)     missNext = '0;
    else if (missCnt < LIMIT) missNext = missCnt + 1'b1;
    else                    missNext = missCnt;
  end

  assign lastStep = (stepCnt >= stepsNeeded - 1'b1);
  assign complete = ctrl.shiftEn && lastStep;

  always_comb begin
    ctrl.shiftEn  = rxEnable && bitStrobe;
    ctrl.goIdle   = (missNext == LIMIT);
    ctrl.loadWord = complete && framingOk && parityOk;
    ctrl.laneCnt  = laneCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      missCnt     <= LIMIT;
      stepCnt     <= '0;
      pixelStrobe <= 1'b0;
      parityErr   <= 1'b0;
    end else begin
      missCnt     <= missNext;
      pixelStrobe <= complete && framingOk;
      parityErr   <= complete && framingOk && !parityOk;
      if (ctrl.goIdle)
        stepCnt <= '0;
      else if (ctrl.shiftEn) begin
        if (!lastStep)      stepCnt <= stepCnt + 1'b1;
        else if (framingOk) stepCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/pix_deser_dp.sv
module pix_deser_dp
  import pix_deser_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_t                ctrl,
  input  logic [MAX_LANES-1:0] serialIn,
  input  logic                 swapOrder,
  output logic                 framingOk,
  output logic                 parityOk,
  output logic [DATA_W-1:0]    pixelOut
);
  logic [FRAME_W-1:0] frameBuf, nextBuf;
  logic [DATA_W-1:0]  wordReg, swapped;
  logic [STEP_W-1:0]  topBase;

  assign topBase = STEP_W'(FRAME_W) - {{(STEP_W-2){1'b0}}, ctrl.laneCnt};

  always_comb begin
    nextBuf = frameBuf >> ctrl.laneCnt;
    for (int i = 0; i < MAX_LANES; i++)
      if (i < int'(ctrl.laneCnt))
        nextBuf[topBase + STEP_W'(i)] = serialIn[i];
  end

  assign framingOk = nextBuf[SYNC0_POS] && !nextBuf[SYNC1_POS];
  assign parityOk  = ~^nextBuf[PAR_POS:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameBuf <= '0;
      wordReg  <= IDLE_WORD;
    end else begin
      if (ctrl.shiftEn)       frameBuf <= nextBuf;
      if (ctrl.goIdle)        wordReg  <= IDLE_WORD;
      else if (ctrl.loadWord) wordReg  <= nextBuf[DATA_W-1:0];
    end
  end

  for (genvar b = 0; b < COLOR_W; b++) begin : g_mirror
    assign swapped[DATA_W-1-b]          = wordReg[BLUE_LO+b];
    assign swapped[RED_LO-1-b]          = wordReg[GREEN_LO+b];
    assign swapped[GREEN_LO-1-b]        = wordReg[RED_LO+b];
  end
  assign swapped[BLUE_LO-1:0] = wordReg[BLUE_LO-1:0];

  assign pixelOut = swapOrder ? swapped : wordReg;
endmodule

// File: rtl/pix_deser.sv
module pix_deser
  import pix_deser_pkg::*;
#(
  parameter int IDLE_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxEnable,
  input  logic [1:0]  linkSel,
  input  logic        bitStrobe,
  input  logic [2:0]  serialIn,
  input  logic        swapOrder,
  output logic [26:0] pixelOut,
  output logic        pixelStrobe,
  output logic        parityErr
);
  ctrl_t ctrl;
  logic  framingOk, parityOk;

  pix_deser_ctrl #(.IDLE_LIMIT(IDLE_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .linkSel(linkSel),
    .bitStrobe(bitStrobe), .framingOk(framingOk), .parityOk(parityOk),
    .ctrl(ctrl), .pixelStrobe(pixelStrobe), .parityErr(parityErr)
  );

  pix_deser_dp u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .serialIn(serialIn),
    .swapOrder(swapOrder), .framingOk(framingOk), .parityOk(parityOk),
    .pixelOut(pixelOut)
  );
endmodule

// File: rtl/pix_deser_chk.sv
module pix_deser_chk
  import pix_deser_pkg::*;
#(
  parameter int IDLE_LIMIT = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        rxEnable,
  input logic        bitStrobe,
  input logic        swapOrder,
  input logic [26:0] pixelOut,
  input logic        pixelStrobe,
  input logic        parityErr
);
  int gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     gapCnt <= IDLE_LIMIT;
    else if (!rxEnable)            gapCnt <= IDLE_LIMIT;
    else if (bitStrobe)            gapCnt <= 0;
    else if (gapCnt < IDLE_LIMIT)  gapCnt <= gapCnt + 1;
  end

  AST_ERR_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> pixelStrobe); // R3
  AST_ERR_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && $stable(swapOrder)) |-> $stable(pixelOut)); // R3
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> !parityErr); // R3
  AST_STROBE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    pixelStrobe |-> $past(bitStrobe && rxEnable)); // R2
  AST_SHUTDOWN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (pixelOut == IDLE_WORD && !pixelStrobe && !parityErr)); // R7
  AST_LOST_CLOCK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (gapCnt >= IDLE_LIMIT) |-> (pixelOut == IDLE_WORD && !pixelStrobe)); // R6
endmodule

bind pix_deser pix_deser_chk #(.IDLE_LIMIT(IDLE_LIMIT)) u_chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .bitStrobe(bitStrobe),
  .swapOrder(swapOrder), .pixelOut(pixelOut), .pixelStrobe(pixelStrobe),
  .parityErr(parityErr)
);

// File: tb/pix_deser_tb.sv
module pix_deser_tb;
  localparam int LIMIT = 16;
  localparam logic [26:0] IDLE = 27'h7FFFFFE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b0;
  logic [1:0] linkSel = 2'b00;
  logic bitStrobe = 1'b0;
  logic [2:0] serialIn = 3'b000;
  logic swapOrder = 1'b0;
  logic [26:0] pixelOut;
  logic pixelStrobe, parityErr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference model state
  bit q[$];
  int missCnt = LIMIT;
  logic [26:0] expWord = IDLE;
  logic expStrobe = 0, expErr = 0;
  string tag = "R8";

  always #5 clk = ~clk;

  pix_deser #(.IDLE_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .linkSel(linkSel),
    .bitStrobe(bitStrobe), .serialIn(serialIn), .swapOrder(swapOrder),
    .pixelOut(pixelOut), .pixelStrobe(pixelStrobe), .parityErr(parityErr)
  );

  function automatic int lanesOf(logic [1:0] sel);
    return (sel == 2'b00) ? 1 : (sel == 2'b01) ? 2 : 3;
  endfunction

  function automatic logic [26:0] viewOf(logic [26:0] w, logic sw);
    logic [26:0] r;
    if (!sw) return w;
    r = w;
    for (int b = 0; b < 8; b++) begin
      r[26 - b] = w[3 + b];   // blue reversed on top
      r[18 - b] = w[11 + b];  // green reversed
      r[10 - b] = w[19 + b];  // red reversed at bottom
    end
    return r;
  endfunction

  task automatic modelEdge();
    int n = lanesOf(linkSel);
    bit par;
    expStrobe = 0; expErr = 0;
    if (!rxEnable) missCnt = LIMIT;
    else if (bitStrobe) missCnt = 0;
    else if (missCnt < LIMIT) missCnt++;
    if (missCnt == LIMIT) begin
      q.delete();
      expWord = IDLE;
    end else if (bitStrobe) begin
      for (int i = 0; i < n; i++) q.push_back(serialIn[i]);
      if (q.size() >= 30) begin
        if (q[28] == 1 && q[29] == 0) begin
          par = 0;
          for (int k = 0; k < 28; k++) par ^= q[k];
          expStrobe = 1;
          if (par == 0) for (int k = 0; k < 27; k++) expWord[k] = q[k];
          else expErr = 1;
          q.delete();
        end else begin
          for (int i = 0; i < n; i++) void'(q.pop_front());
        end
      end
    end
  endtask

  task automatic compareNow();
    logic [26:0] ev = viewOf(expWord, swapOrder);
    compared++;
    if (pixelOut !== ev || pixelStrobe !== expStrobe || parityErr !== expErr) begin
      mismatched++;
      $display("FAIL %s: pixelOut=%h exp %h strobe=%b exp %b err=%b exp %b",
               tag, pixelOut, ev, pixelStrobe, expStrobe, parityErr, expErr);
    end
  endtask

  task automatic cyc(input logic str, input logic [2:0] lanes);
    bitStrobe = str;
    serialIn  = lanes;
    @(posedge clk);
    #1 modelEdge();
    @(negedge clk);
    compareNow();
  endtask

  task automatic sendFrame(input logic [26:0] w, input bit badPar, input bit badSync);
    logic [29:0] f;
    logic [2:0] l;
    int n = lanesOf(linkSel);
    f[26:0] = w;
    f[27] = (^w) ^ badPar;
    f[28] = ~badSync;
    f[29] = 1'b0;
    for (int s = 0; s < 30 / n; s++) begin
      l = '0;
      for (int i = 0; i < n; i++) l[i] = f[s * n + i];
      cyc(1'b1, l);
      cyc(1'b0, 3'b000);
    end
  endtask

  task automatic directCheck(input string t, input logic [26:0] exp);
    compared++;
    if (pixelOut !== exp) begin
      mismatched++;
      $display("FAIL %s: pixelOut=%h exp %h", t, pixelOut, exp);
    end
  endtask

  task automatic relink(input logic [1:0] sel);
    tag = "R7";
    rxEnable = 1'b0;
    cyc(1'b0, 3'b000);
    linkSel = sel;
    rxEnable = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    directCheck("R8 in reset", IDLE);
    rstN = 1'b1;
    tag = "R8";
    cyc(1'b0, 3'b000);
    directCheck("R8 after reset", IDLE);

    // R1 / R2: single lane
    rxEnable = 1'b1;
    tag = "R1";
    sendFrame(27'h5A3C7E1, 0, 0);
    directCheck("R2 single lane word", 27'h5A3C7E1);
    sendFrame(27'h0123456, 0, 0);

    relink(2'b01); tag = "R1";
    sendFrame(27'h7F00FF5, 0, 0);
    directCheck("R1 two lanes", 27'h7F00FF5);

    relink(2'b10); tag = "R2";
    sendFrame(27'h1234567, 0, 0);
    sendFrame(27'h2AAAAAA, 0, 0);
    directCheck("R2 three lanes", 27'h2AAAAAA);

    relink(2'b11); tag = "R9";
    sendFrame(27'h3C3C3C3, 0, 0);
    directCheck("R9 code 11 as 3 lanes", 27'h3C3C3C3);

    // R3: bad parity dropped
    tag = "R3";
    sendFrame(27'h0F0F0F0, 1, 0);
    directCheck("R3 word held", 27'h3C3C3C3);
    sendFrame(27'h0F0F0F0, 0, 0);

    // R4: misaligned start, red field zero avoids false lock
    relink(2'b10); tag = "R4";
    cyc(1'b1, 3'b111); cyc(1'b0, 3'b000);
    cyc(1'b1, 3'b101); cyc(1'b0, 3'b000);
    sendFrame(27'h007FFF8, 0, 0);
    sendFrame(27'h00155A9, 0, 0);
    directCheck("R4 relocked", 27'h00155A9);
    sendFrame(27'h4444444, 0, 1);
    sendFrame(27'h5555555, 0, 0);

    // R5: swapped output order
    tag = "R5";
    swapOrder = 1'b1;
    sendFrame(27'h6B2D1F3, 0, 0);
    swapOrder = 1'b0; cyc(1'b0, 3'b000);
    swapOrder = 1'b1; cyc(1'b0, 3'b000);
    sendFrame(27'h6B2D1F3, 1, 0);
    swapOrder = 1'b0;

    // R6: clock loss mid-frame
    tag = "R6";
    cyc(1'b1, 3'b011); cyc(1'b0, 3'b000);
    cyc(1'b1, 3'b110);
    for (int i = 0; i < LIMIT + 4; i++) cyc(1'b0, 3'b000);
    directCheck("R6 idle pattern", IDLE);
    sendFrame(27'h1111111, 0, 0);
    directCheck("R6 fresh frame after loss", 27'h1111111);

    // R7: shutdown mid-frame, strobes ignored
    tag = "R7";
    cyc(1'b1, 3'b101); cyc(1'b0, 3'b000);
    rxEnable = 1'b0;
    for (int i = 0; i < 6; i++) cyc(1'b1, 3'b111);
    directCheck("R7 shutdown idle", IDLE);
    rxEnable = 1'b1;
    sendFrame(27'h2468ACE, 0, 0);
    directCheck("R7 restart from bit 0", 27'h2468ACE);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule